// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt requests and drives two processor lines: a normal interrupt line (IRQ) and a fast interrupt line (FIQ). Software works it through a simple 32-bit register bus. Each source can be enabled or disabled, raised from software, and routed to either line. Enable and software-raise changes go through separate write-one set and clear registers, so that no read-modify-write is needed.

For IRQ traffic there are sixteen programmable vector slots. Each slot names one source and holds a handler address, and a lower slot number means a higher priority. The interrupt service routine reads the vector-address register to claim the winning request and get its handler address. That read also pushes the claimed priority onto an in-service stack, which hides the claimed slot and every lower-priority slot from IRQ. Writing any value to the same register ends the most recent claim. A request that no enabled slot names is served through a default address.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous reset, `irq_o` and `fiq_o` are 0. The enable mask, the soft bits, the route bits and every slot control read back as 0, and no claim is in service.
- R2: A write to 0x010 sets the enable bits written as 1, and a write to 0x014 clears the enable bits written as 1. Zero bits leave their enable bits unchanged. A read of 0x010 returns the enable mask.
- R3: A write to 0x018 sets soft bits and a write to 0x01C clears soft bits, both with write-one semantics, and a read of 0x018 returns the soft bits. A source is pending when its input or its soft bit is 1, and 0x008 reads the pending word.
- R4: Route register 0x00C sends a source to IRQ when its bit is 0 and to FIQ when its bit is 1. `fiq_o` is the OR of enabled, pending, FIQ-routed sources, registered once. 0x000 reads pending&enable&~route and 0x004 reads pending&enable&route.
- R5: Slot i has a control word at 0x200+4i, with bit 5 the slot enable and bits 4:0 the source number, and a handler address at 0x100+4i. Both are read/write.
- R6: A read of 0x030 returns the handler address of the lowest-numbered enabled slot whose source has an enabled, pending, IRQ-routed request and whose number is below the current nesting level. Read data appears one cycle after the read strobe.
- R7: If no slot qualifies, a read of 0x030 returns the default address held at 0x034. The claim is pushed at a level below all slots only when an unvectored IRQ request is pending and nothing is in service. Otherwise nothing is pushed.
- R8: After a claim of slot k, sources whose highest-priority slot is k or higher-numbered, and unvectored sources, no longer raise `irq_o`. A source in a lower-numbered slot still raises `irq_o` and can be claimed, which nests.
- R9: Any write to 0x030 ends the most recent outstanding claim. With no claim outstanding it has no effect, so read/write pairs issued from reset always leave the stack empty.
- R10: Reads at 0xFE0, 0xFE4, 0xFE8 and 0xFEC return bytes 0 to 3 of the 32-bit `CELL_ID` in bits 7:0. Bits 19:12 of the assembled word are the vendor code.
- R11: An FIQ-routed source is never vectored. A slot naming it does not win, and it never raises `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (a read of 0x030 claims) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid the cycle after `bus_re` |
| src_in | input | 32 | Level-sensitive interrupt request inputs |
| irq_o | output | 1 | Registered normal interrupt line |
| fiq_o | output | 1 | Registered fast interrupt line |

## Verification
The assertions assume that a bus cycle never carries `bus_re` and `bus_we` together. Under that assumption a push and a pop of the nesting stack never coincide. They also assume that software claims only in response to a request, so any pushed level is strictly above the current one. The bench keeps to both: every access is a single-strobe task that spans one clock, and claims are issued only when the bench has itself raised a request. Priority ordering is checked by sweeping every slot one at a time and by a two-deep nested claim. Routing and enables are swept over all 32 sources.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam logic [11:0] A_IRQ_STAT  = 12'h000;
  localparam logic [11:0] A_FIQ_STAT  = 12'h004;
  localparam logic [11:0] A_RAW       = 12'h008;
  localparam logic [11:0] A_ROUTE     = 12'h00C;
  localparam logic [11:0] A_EN_SET    = 12'h010;
  localparam logic [11:0] A_EN_CLR    = 12'h014;
  localparam logic [11:0] A_SW_SET    = 12'h018;
  localparam logic [11:0] A_SW_CLR    = 12'h01C;
  localparam logic [11:0] A_VEC       = 12'h030;
  localparam logic [11:0] A_DEF       = 12'h034;
  localparam logic [3:0]  PAGE_SLOT_A = 4'h1;
  localparam logic [3:0]  PAGE_SLOT_C = 4'h2;
  localparam logic [7:0]  PAGE_ID     = 8'hFE;
endpackage

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int SW    = $clog2(NSRC),
  parameter int LW    = $clog2(NSLOT + 2)
) (
  input  logic [NSLOT-1:0]         slot_en,
  input  logic [NSLOT-1:0][SW-1:0] slot_src,
  input  logic [NSRC-1:0]          irq_req,
  input  logic [LW-1:0]            cur_level,
  output logic                     irq_unmasked,
  output logic                     win_valid,
  output logic [LW-1:0]            win_slot,
  output logic                     dflt_valid
);
  logic [LW-1:0] lvl [NSRC];

  // Priority level of each source: its lowest-numbered enabled slot, else NSLOT.
  always_comb begin
    for (int s = 0; s < NSRC; s++) begin
      lvl[s] = LW'(NSLOT);
      for (int i = NSLOT - 1; i >= 0; i--)
        if (slot_en[i] && slot_src[i] == SW'(s)) lvl[s] = LW'(i);
    end
  end

  always_comb begin
    irq_unmasked = 1'b0;
    dflt_valid   = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      if (irq_req[s] && lvl[s] < cur_level) irq_unmasked = 1'b1;
      if (irq_req[s] && lvl[s] == LW'(NSLOT) && cur_level > LW'(NSLOT)) dflt_valid = 1'b1;
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_slot  = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (slot_en[i] && irq_req[slot_src[i]] && LW'(i) < cur_level) begin
        win_valid = 1'b1;
        win_slot  = LW'(i);
      end
  end
endmodule

// File: rtl/vic_nest.sv
module vic_nest #(
  parameter int NSLOT = 16,
  parameter int LW    = $clog2(NSLOT + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [LW-1:0] cur_level
);
  logic [NSLOT:0] in_svc;

  always_comb begin
    cur_level = LW'(NSLOT + 1);
    for (int i = NSLOT; i >= 0; i--)
      if (in_svc[i]) cur_level = LW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) in_svc <= '0;
    else begin
      logic [NSLOT:0] nxt;
      nxt = in_svc;
      if (pop && in_svc != '0) nxt[cur_level] = 1'b0;
      if (push) nxt[push_lvl] = 1'b1;
      in_svc <= nxt;
    end
  end

  // R8
  push_order_chk: assert property (@(posedge clk) disable iff (rst)
    push |-> push_lvl < cur_level);
  // R9
  pop_unwind_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && in_svc != '0) |=> $countones(in_svc) == $countones($past(in_svc)) - 1);
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && in_svc == '0) |=> in_svc == '0);
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int          NSRC    = 32,
  parameter int          NSLOT   = 16,
  parameter logic [31:0] CELL_ID = 32'h0A05_3C21
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [11:0] bus_addr,
  input  logic        bus_we,
  input  logic        bus_re,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic [31:0] src_in,
  output logic        irq_o,
  output logic        fiq_o
);
  import vic_pkg::*;
  localparam int SW = $clog2(NSRC);
  localparam int LW = $clog2(NSLOT + 2);
  localparam int IW = $clog2(NSLOT);

  logic [NSRC-1:0] en_q, sw_q, sel_q, pending, irq_req, fiq_req;
  logic [31:0] def_q;
  logic [31:0] slot_addr [NSLOT];
  logic [NSLOT-1:0]         slot_en;
  logic [NSLOT-1:0][SW-1:0] slot_src;

  logic [LW-1:0] cur_level, win_slot, push_lvl;
  logic irq_unmasked, win_valid, dflt_valid, push, pop;
  logic slot_hit_a, slot_hit_c, id_hit;
  logic [IW-1:0] sidx;
  logic [31:0] vec_val, rd_nxt;

  assign pending = src_in[NSRC-1:0] | sw_q;
  assign irq_req = pending & en_q & ~sel_q;
  assign fiq_req = pending & en_q & sel_q;

  assign sidx       = bus_addr[2 +: IW];
  assign slot_hit_a = bus_addr[11:8] == PAGE_SLOT_A && int'(bus_addr[7:2]) < NSLOT && bus_addr[1:0] == 2'b00;
  assign slot_hit_c = bus_addr[11:8] == PAGE_SLOT_C && int'(bus_addr[7:2]) < NSLOT && bus_addr[1:0] == 2'b00;
  assign id_hit     = bus_addr[11:4] == PAGE_ID && bus_addr[1:0] == 2'b00;

  vic_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .SW(SW), .LW(LW)) u_prio (
    .slot_en(slot_en), .slot_src(slot_src), .irq_req(irq_req), .cur_level(cur_level),
    .irq_unmasked(irq_unmasked), .win_valid(win_valid), .win_slot(win_slot),
    .dflt_valid(dflt_valid));

  assign push     = bus_re && bus_addr == A_VEC && (win_valid || dflt_valid);
  assign push_lvl = win_valid ? win_slot : LW'(NSLOT);
  assign pop      = bus_we && bus_addr == A_VEC;

  vic_nest #(.NSLOT(NSLOT), .LW(LW)) u_nest (
    .clk(clk), .rst(rst), .push(push), .push_lvl(push_lvl), .pop(pop),
    .cur_level(cur_level));

  assign vec_val = win_valid ? slot_addr[win_slot[IW-1:0]] : def_q;

  // Control and mask registers
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0; sw_q <= '0; sel_q <= '0; def_q <= '0;
      slot_en <= '0; slot_src <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_EN_SET: en_q  <= en_q | bus_wdata[NSRC-1:0];
        A_EN_CLR: en_q  <= en_q & ~bus_wdata[NSRC-1:0];
        A_SW_SET: sw_q  <= sw_q | bus_wdata[NSRC-1:0];
        A_SW_CLR: sw_q  <= sw_q & ~bus_wdata[NSRC-1:0];
        A_ROUTE:  sel_q <= bus_wdata[NSRC-1:0];
        A_DEF:    def_q <= bus_wdata;
        default: if (slot_hit_c) begin
          slot_en[sidx]  <= bus_wdata[5];
          slot_src[sidx] <= bus_wdata[SW-1:0];
        end
      endcase
    end
  end

  // Handler address storage, one write port, no reset
  always_ff @(posedge clk)
    if (bus_we && slot_hit_a) slot_addr[sidx] <= bus_wdata;

  always_comb begin
    rd_nxt = '0;
    case (bus_addr)
      A_IRQ_STAT: rd_nxt = 32'(irq_req);
      A_FIQ_STAT: rd_nxt = 32'(fiq_req);
      A_RAW:      rd_nxt = 32'(pending);
      A_ROUTE:    rd_nxt = 32'(sel_q);
      A_EN_SET:   rd_nxt = 32'(en_q);
      A_SW_SET:   rd_nxt = 32'(sw_q);
      A_VEC:      rd_nxt = vec_val;
      A_DEF:      rd_nxt = def_q;
      default: begin
        if (slot_hit_a) rd_nxt = slot_addr[sidx];
        if (slot_hit_c) rd_nxt = 32'({slot_en[sidx], slot_src[sidx]});
        if (id_hit)     rd_nxt = 32'(CELL_ID[8*bus_addr[3:2] +: 8]);
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0; irq_o <= 1'b0; fiq_o <= 1'b0;
    end else begin
      if (bus_re) bus_rdata <= rd_nxt;
      irq_o <= irq_unmasked;
      fiq_o <= |fiq_req;
    end
  end

  // R2
  en_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_EN_CLR) |=> (en_q & $past(bus_wdata[NSRC-1:0])) == '0);
  // R3
  soft_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == A_SW_SET) |=> (sw_q & $past(bus_wdata[NSRC-1:0])) == $past(bus_wdata[NSRC-1:0]));
  // R11
  fiq_no_vec_chk: assert property (@(posedge clk) disable iff (rst)
    (win_valid) |-> !sel_q[slot_src[win_slot[IW-1:0]]]);
endmodule

// File: tb/sim_irq_vector_ctrl.sv
module sim_irq_vector_ctrl;
  logic clk = 1'b0, rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_wdata = '0, src_in = '0;
  logic [31:0] bus_rdata;
  logic irq_o, fiq_o;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  localparam logic [31:0] ID = 32'h0A05_3C21;
  localparam logic [31:0] DEF = 32'h0000_0F00;

  always #5 clk = ~clk;

  irq_vector_ctrl u0 (.clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_re(bus_re), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_o(irq_o), .fiq_o(fiq_o));

  function automatic logic [31:0] vaddr(int i); return 32'h8000_0004 + 32'(i) * 32'h40; endfunction
  function automatic int ssrc(int i); return (i * 3 + 1) % 32; endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic settle(); repeat (2) @(negedge clk); endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [31:0] d, idw;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq_o", 32'(irq_o), 0);
    chk("R1 fiq_o", 32'(fiq_o), 0);
    rd(12'h010, d); chk("R1 enable", d, 0);
    rd(12'h018, d); chk("R1 soft", d, 0);
    rd(12'h00C, d); chk("R1 route", d, 0);
    rd(12'h200, d); chk("R1 slot ctl", d, 0);
    // R9 unwind from reset
    for (int k = 0; k < 19; k++) begin rd(12'h030, d); wr(12'h030, d); end
    wr(12'h034, DEF);
    // R2 / R4 sweep over all sources
    for (int s = 0; s < 32; s++) begin
      logic [31:0] b; b = 32'h1 << s;
      wr(12'h014, 32'hFFFF_FFFF);
      src_in = b;
      wr(12'h00C, (s % 2) ? b : 32'h0);
      wr(12'h010, b);
      wr(12'h014, ~b);
      settle();
      rd(12'h010, d); chk("R2 zero bits keep enable", d, b);
      chk("R4 irq_o route", 32'(irq_o), (s % 2) ? 0 : 1);
      chk("R4 fiq_o route", 32'(fiq_o), (s % 2) ? 1 : 0);
      rd((s % 2) ? 12'h004 : 12'h000, d); chk("R4 status", d, b);
    end
    wr(12'h014, 32'hFFFF_FFFF); src_in = 0; settle();
    chk("R2 disabled irq_o", 32'(irq_o), 0);
    chk("R2 disabled fiq_o", 32'(fiq_o), 0);
    // R3 soft sweep
    wr(12'h00C, 0); wr(12'h010, 32'hFFFF_FFFF);
    for (int s = 0; s < 32; s++) begin
      logic [31:0] b; b = 32'h1 << s;
      wr(12'h018, b); wr(12'h01C, ~b); settle();
      rd(12'h008, d); chk("R3 raw pending", d, b);
      chk("R3 soft raises irq", 32'(irq_o), 1);
      wr(12'h01C, b);
      rd(12'h018, d); chk("R3 soft cleared", d, 0);
    end
    // R5 program slots
    for (int i = 0; i < 16; i++) begin
      wr(12'h100 + 12'(4 * i), vaddr(i));
      wr(12'h200 + 12'(4 * i), 32'h20 | 32'(ssrc(i)));
    end
    for (int i = 0; i < 16; i++) begin
      rd(12'h200 + 12'(4 * i), d); chk("R5 slot ctl", d, 32'h20 | 32'(ssrc(i)));
      rd(12'h100 + 12'(4 * i), d); chk("R5 slot addr", d, vaddr(i));
    end
    // R6 each slot in turn, claim masks it (R8), end releases (R9)
    for (int i = 0; i < 16; i++) begin
      src_in = 32'h1 << ssrc(i); settle();
      chk("R6 request irq_o", 32'(irq_o), 1);
      rd(12'h030, d); chk("R6 vector", d, vaddr(i));
      settle(); chk("R8 claimed masked", 32'(irq_o), 0);
      wr(12'h030, 0); settle(); chk("R9 end re-arms", 32'(irq_o), 1);
      src_in = 0;
    end
    // R6 priority with two requests: slot 2 beats slot 5
    src_in = (32'h1 << ssrc(5)) | (32'h1 << ssrc(2)); settle();
    rd(12'h030, d); chk("R6 priority", d, vaddr(2));
    wr(12'h030, 0); src_in = 0; settle();
    // R8 nesting
    src_in = 32'h1 << ssrc(5); settle();
    rd(12'h030, d); chk("R8 outer claim", d, vaddr(5));
    settle(); chk("R8 outer masked", 32'(irq_o), 0);
    src_in = src_in | (32'h1 << ssrc(2)); settle();
    chk("R8 higher breaks through", 32'(irq_o), 1);
    rd(12'h030, d); chk("R8 inner claim", d, vaddr(2));
    settle(); chk("R8 inner masked", 32'(irq_o), 0);
    src_in = 32'h1 << ssrc(5);
    wr(12'h030, 0); settle(); chk("R9 pop inner keeps outer", 32'(irq_o), 0);
    wr(12'h030, 0); settle(); chk("R9 pop outer", 32'(irq_o), 1);
    src_in = 0; settle();
    // R7 default vector
    src_in = 32'h1; settle();
    rd(12'h030, d); chk("R7 default addr", d, DEF);
    settle(); chk("R7 default claim masks", 32'(irq_o), 0);
    wr(12'h030, 0); settle(); chk("R7 default end", 32'(irq_o), 1);
    src_in = 32'h1 | (32'h1 << ssrc(3)); settle();
    rd(12'h030, d); chk("R7 vectored preferred", d, vaddr(3));
    wr(12'h030, 0); src_in = 0; settle();
    rd(12'h030, d); chk("R7 idle read default", d, DEF);
    // R9 write with empty stack has no effect
    wr(12'h030, 0); wr(12'h030, 0);
    src_in = 32'h1 << ssrc(0); settle();
    rd(12'h030, d); chk("R9 empty writes harmless", d, vaddr(0));
    wr(12'h030, 0); src_in = 0; settle();
    // R11 FIQ source in slot 0 not vectored
    wr(12'h00C, 32'h1 << ssrc(0));
    src_in = 32'h1 << ssrc(0); settle();
    chk("R11 fiq_o", 32'(fiq_o), 1);
    chk("R11 irq_o", 32'(irq_o), 0);
    rd(12'h030, d); chk("R11 not vectored", d, DEF);
    src_in = 0; wr(12'h00C, 0); settle();
    // R10 identification bytes
    idw = 0;
    for (int k = 0; k < 4; k++) begin
      rd(12'hFE0 + 12'(4 * k), d);
      chk("R10 id byte", d, 32'(ID[8 * k +: 8]));
      idw = idw | ((d & 32'hFF) << (8 * k));
    end
    chk("R10 vendor", 32'(idw[19:12]), 32'h53);
    finish_up();
  end
endmodule